// File: doc/BRIEF.md
# Oscillator Noise Decimator and Block Accumulator

This block collects raw entropy from a bank of free-running ring oscillators and groups it for a downstream conditioner. On every clock in which it runs, the oscillators whose mask bit is set are combined by XOR into one raw sample bit. A programmable number of consecutive raw bits are then folded together by XOR into one decimated bit. Each decimated bit enters a shift register. The shift register yields an 8-bit noise sample after every eighth bit and a complete raw block after every `BLOCK_BITS` bits.

A block counter tracks how many raw blocks have been produced. When it reaches the programmed quota, a one-cycle completion pulse tells the conditioner that it has enough input for one full-entropy result. The counter then starts again. For each 8-bit field, the value 0 selects the maximum: 65536 folds per bit, or 256 blocks per quota. A typical quota of 5 blocks of 512 bits supplies 2560 sample bits for a 160-bit conditioned output.

Software sets the two configuration fields while the block is stopped. The block latches them and holds them for the whole run. Dropping the run input returns the folding and counting state to its start.

Top module: `noise_accumulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe output (`fold_vld`, `smp_vld`, `blk_vld`, `done`) is 0.
- R2: The raw bit of a running cycle is the XOR of those `osc_in` bits whose `src_mask` bit is 1. Sources whose mask bit is 0 have no effect, and an all-zero mask yields only zero decimated bits.
- R3: With a latched fold value N in 1..255, each decimated bit is the XOR of N consecutive raw bits. `fold_vld` is high for one cycle, starting the cycle after the edge that samples the Nth raw bit, and `fold_bit` carries the result. A fold value of 0 selects 65536 raw bits.
- R4: Each decimated bit shifts into the least significant end of the shift register. After every 8th bit since the start of a run, `smp_vld` pulses together with `fold_vld`, and `smp_byte` holds those 8 bits with the earliest bit in bit 7.
- R5: After every `BLOCK_BITS` decimated bits, `blk_vld` pulses together with `smp_vld`. In that cycle `blk_data` holds the block with the earliest bit in the most significant position.
- R6: With a latched block quota K in 1..255, `done` pulses for one cycle together with the `blk_vld` of every Kth block, and the block count then restarts. A quota of 0 selects 256 blocks.
- R7: While `run_en` is 0, no strobe is produced, and the XOR accumulator, the bit counter and the block counter return to their start. A new run begins with a fresh fold window, sample, block and quota.
- R8: `fold_cfg` and `blk_cfg` are latched only on clocks where `run_en` is 0. Changes while running have no effect until the block is stopped again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low clears the accumulation state and latches the configuration |
| src_mask | input | NUM_SRC | Per-oscillator enable mask |
| osc_in | input | NUM_SRC | Oscillator sample bits |
| fold_cfg | input | FOLD_W | Raw bits folded into one decimated bit (0 selects 2^FOLD_MAX_LOG2) |
| blk_cfg | input | BLK_W | Blocks per quota (0 selects 2^BLK_W) |
| fold_vld | output | 1 | Decimated bit strobe |
| fold_bit | output | 1 | Decimated bit value |
| smp_vld | output | 1 | 8-bit noise sample strobe |
| smp_byte | output | SMP_BITS | Most recent noise sample |
| blk_vld | output | 1 | Raw block strobe |
| blk_data | output | BLOCK_BITS | Raw block contents |
| done | output | 1 | Block quota reached |

## Verification
A behavioural model runs beside the block, and its outputs are compared every cycle. The block is driven with pseudo-random oscillators under a full mask and under a sparse mask, which shows whether each source is gated individually. An all-zero mask separates gating from folding. A single source that toggles every cycle, folded in pairs, must give an all-ones stream; this exposes an off-by-one in the fold window. Further sequences stop the block mid-block, reprogram it while it is running, and set each field to 0. These check the restart behaviour, configuration latching, and the two maximum settings (256 blocks and 65536 folds).

// File: rtl/noise_acc_pkg.sv
package noise_acc_pkg;

   // One decimation event handed from the folding stage to the assembler.
   typedef struct packed {
      logic fire;
      logic bit_val;
   } fold_evt_t;

   localparam int DEF_NUM_SRC    = 24;
   localparam int DEF_FIELD_W    = 8;
   localparam int DEF_FOLD_LOG2  = 16;
   localparam int DEF_SMP_BITS   = 8;
   localparam int DEF_BLOCK_BITS = 512;

endpackage

// File: rtl/nacc_combiner.sv
module nacc_combiner #(
   parameter int NUM_SRC = 24
) (
   input  logic [NUM_SRC-1:0] osc_in,
   input  logic [NUM_SRC-1:0] src_mask,
   output logic               raw_bit
);

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("nacc_combiner: NUM_SRC must be at least 1");
      end

      if (NUM_SRC == 1) begin : g_single
         assign raw_bit = osc_in[0] & src_mask[0];
      end else begin : g_reduce
         logic [NUM_SRC-1:0] gated;
         assign gated   = osc_in & src_mask;
         assign raw_bit = ^gated;
      end
   endgenerate

endmodule

// File: rtl/nacc_decimator.sv
module nacc_decimator
   import noise_acc_pkg::*;
#(
   parameter int FOLD_W        = 8,
   parameter int FOLD_MAX_LOG2 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              raw_bit,
   input  logic [FOLD_W-1:0] fold_cfg,
   output fold_evt_t         evt
);

   localparam int            CW       = FOLD_MAX_LOG2 + 1;
   localparam logic [CW-1:0] FOLD_MAX = CW'(1) << FOLD_MAX_LOG2;

   generate
      if (FOLD_W > FOLD_MAX_LOG2) begin : g_bad_fold
         $error("nacc_decimator: fold field wider than the maximum fold count");
      end
   endgenerate

   logic [CW-1:0] lim;
   logic [CW-1:0] cnt_q;
   logic          acc_q;
   logic          last;
   logic          folded;

   always_comb begin
      lim         = (fold_cfg == '0) ? FOLD_MAX : CW'(fold_cfg);
      last        = (cnt_q == (lim - CW'(1)));
      folded      = acc_q ^ raw_bit;
      evt.fire    = run_en & last;
      evt.bit_val = folded;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= 1'b0;
      end else if (!run_en || last) begin
         cnt_q <= '0;
         acc_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
         acc_q <= folded;
      end
   end

endmodule

// File: rtl/nacc_assembler.sv
module nacc_assembler
   import noise_acc_pkg::*;
#(
   parameter int SMP_BITS   = 8,
   parameter int BLOCK_BITS = 512,
   parameter int BLK_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_en,
   input  fold_evt_t             evt,
   input  logic [BLK_W-1:0]      blk_cfg,
   output logic                  fold_vld,
   output logic                  fold_bit,
   output logic                  smp_vld,
   output logic [SMP_BITS-1:0]   smp_byte,
   output logic                  blk_vld,
   output logic [BLOCK_BITS-1:0] blk_data,
   output logic                  done
);

   localparam int            BCW     = $clog2(BLOCK_BITS);
   localparam int            SBW     = $clog2(SMP_BITS);
   localparam int            KW      = BLK_W + 1;
   localparam logic [KW-1:0] BLK_MAX = KW'(1) << BLK_W;

   generate
      if (SMP_BITS < 2 || (SMP_BITS & (SMP_BITS - 1)) != 0) begin : g_bad_smp
         $error("nacc_assembler: SMP_BITS must be a power of two of at least 2");
      end
      if (BLOCK_BITS < SMP_BITS || (BLOCK_BITS % SMP_BITS) != 0) begin : g_bad_blk
         $error("nacc_assembler: BLOCK_BITS must be a multiple of SMP_BITS");
      end
   endgenerate

   logic [BLOCK_BITS-1:0] sreg_q;
   logic [BCW-1:0]        bit_cnt_q;
   logic [KW-1:0]         blk_cnt_q;
   logic [KW-1:0]         blk_lim;
   logic                  byte_end;
   logic                  block_end;
   logic                  quota_end;
   logic                  fold_vld_q;
   logic                  fold_bit_q;
   logic                  smp_vld_q;
   logic                  blk_vld_q;
   logic                  done_q;

   always_comb begin
      blk_lim   = (blk_cfg == '0) ? BLK_MAX : KW'(blk_cfg);
      byte_end  = (bit_cnt_q[SBW-1:0] == '1);
      block_end = (bit_cnt_q == BCW'(BLOCK_BITS - 1));
      quota_end = (blk_cnt_q == (blk_lim - KW'(1)));
   end

   // Shift register: new bits enter at the low end.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (evt.fire) begin
         sreg_q <= {sreg_q[BLOCK_BITS-2:0], evt.bit_val};
      end
   end

   // Bit and block counters.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         blk_cnt_q <= '0;
      end else if (!run_en) begin
         bit_cnt_q <= '0;
         blk_cnt_q <= '0;
      end else if (evt.fire) begin
         bit_cnt_q <= block_end ? '0 : (bit_cnt_q + BCW'(1));
         if (block_end) begin
            blk_cnt_q <= quota_end ? '0 : (blk_cnt_q + KW'(1));
         end
      end
   end

   // Strobes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fold_vld_q <= 1'b0;
         fold_bit_q <= 1'b0;
         smp_vld_q  <= 1'b0;
         blk_vld_q  <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         fold_vld_q <= evt.fire;
         if (evt.fire) begin
            fold_bit_q <= evt.bit_val;
         end
         smp_vld_q <= evt.fire & byte_end;
         blk_vld_q <= evt.fire & block_end;
         done_q    <= evt.fire & block_end & quota_end;
      end
   end

   assign fold_vld = fold_vld_q;
   assign fold_bit = fold_bit_q;
   assign smp_vld  = smp_vld_q;
   assign smp_byte = sreg_q[SMP_BITS-1:0];
   assign blk_vld  = blk_vld_q;
   assign blk_data = sreg_q;
   assign done     = done_q;

endmodule

// File: rtl/noise_accumulator.sv
module noise_accumulator
   import noise_acc_pkg::*;
#(
   parameter int NUM_SRC       = DEF_NUM_SRC,
   parameter int FOLD_W        = DEF_FIELD_W,
   parameter int FOLD_MAX_LOG2 = DEF_FOLD_LOG2,
   parameter int SMP_BITS      = DEF_SMP_BITS,
   parameter int BLOCK_BITS    = DEF_BLOCK_BITS,
   parameter int BLK_W         = DEF_FIELD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_en,
   input  logic [NUM_SRC-1:0]    src_mask,
   input  logic [NUM_SRC-1:0]    osc_in,
   input  logic [FOLD_W-1:0]     fold_cfg,
   input  logic [BLK_W-1:0]      blk_cfg,
   output logic                  fold_vld,
   output logic                  fold_bit,
   output logic                  smp_vld,
   output logic [SMP_BITS-1:0]   smp_byte,
   output logic                  blk_vld,
   output logic [BLOCK_BITS-1:0] blk_data,
   output logic                  done
);

   logic [FOLD_W-1:0] cfg_fold_q;
   logic [BLK_W-1:0]  cfg_blk_q;
   logic              raw_bit;
   fold_evt_t         evt;

   // Configuration is sampled only while stopped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_fold_q <= '0;
         cfg_blk_q  <= '0;
      end else if (!run_en) begin
         cfg_fold_q <= fold_cfg;
         cfg_blk_q  <= blk_cfg;
      end
   end

   nacc_combiner #(
      .NUM_SRC (NUM_SRC)
   ) u_comb (
      .osc_in   (osc_in),
      .src_mask (src_mask),
      .raw_bit  (raw_bit)
   );

   nacc_decimator #(
      .FOLD_W        (FOLD_W),
      .FOLD_MAX_LOG2 (FOLD_MAX_LOG2)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .raw_bit  (raw_bit),
      .fold_cfg (cfg_fold_q),
      .evt      (evt)
   );

   nacc_assembler #(
      .SMP_BITS   (SMP_BITS),
      .BLOCK_BITS (BLOCK_BITS),
      .BLK_W      (BLK_W)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .evt      (evt),
      .blk_cfg  (cfg_blk_q),
      .fold_vld (fold_vld),
      .fold_bit (fold_bit),
      .smp_vld  (smp_vld),
      .smp_byte (smp_byte),
      .blk_vld  (blk_vld),
      .blk_data (blk_data),
      .done     (done)
   );

endmodule

// File: rtl/nacc_checker.sv
module nacc_checker #(
   parameter int FOLD_W = 8,
   parameter int BLK_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              fold_vld,
   input logic              smp_vld,
   input logic              blk_vld,
   input logic              done,
   input logic [FOLD_W-1:0] cfg_fold_q,
   input logic [BLK_W-1:0]  cfg_blk_q
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!fold_vld && !smp_vld && !blk_vld && !done));

   assert_unit_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && cfg_fold_q == FOLD_W'(1)) |=> fold_vld);

   assert_smp_on_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> fold_vld);

   assert_blk_on_smp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld |-> smp_vld);

   assert_done_on_blk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> blk_vld);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!fold_vld && !done));

   assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> ($stable(cfg_fold_q) && $stable(cfg_blk_q)));

endmodule

bind noise_accumulator nacc_checker #(
   .FOLD_W (FOLD_W),
   .BLK_W  (BLK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en     (run_en),
   .fold_vld   (fold_vld),
   .smp_vld    (smp_vld),
   .blk_vld    (blk_vld),
   .done       (done),
   .cfg_fold_q (cfg_fold_q),
   .cfg_blk_q  (cfg_blk_q)
);

// File: tb/tb_noise_accumulator.sv
`timescale 1ns/1ps
module tb_noise_accumulator;

   localparam int NS = 24;
   localparam int BB = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic [NS-1:0] src_mask = '0;
   logic [NS-1:0] osc_in;
   logic [7:0]    fold_cfg = 8'd1;
   logic [7:0]    blk_cfg = 8'd1;
   logic          fold_vld, fold_bit, smp_vld, blk_vld, done;
   logic [7:0]    smp_byte;
   logic [BB-1:0] blk_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   noise_accumulator #(
      .NUM_SRC    (NS),
      .BLOCK_BITS (BB)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .src_mask (src_mask),
      .osc_in   (osc_in),
      .fold_cfg (fold_cfg),
      .blk_cfg  (blk_cfg),
      .fold_vld (fold_vld),
      .fold_bit (fold_bit),
      .smp_vld  (smp_vld),
      .smp_byte (smp_byte),
      .blk_vld  (blk_vld),
      .blk_data (blk_data),
      .done     (done)
   );

   // Oscillator model: pseudo-random or one toggling pattern.
   logic [31:0] lfsr = 32'hACE1_1357;
   logic        tog = 1'b0;
   logic        osc_toggle = 1'b0;
   always @(negedge clk) begin
      lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tog  <= ~tog;
   end
   assign osc_in = osc_toggle ? {NS{tog}} : lfsr[NS-1:0];

   // Behavioural reference model.
   int            m_fold = 0, m_blk = 0, cnt = 0, nbits = 0, nblks = 0;
   logic          acc = 1'b0, raw;
   bit            q[$];
   logic          e_fold_vld = 0, e_fold_bit = 0, e_smp_vld = 0, e_blk_vld = 0, e_done = 0;
   logic [7:0]    e_byte = '0;
   logic [BB-1:0] e_blk = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fold = 0; m_blk = 0; cnt = 0; nbits = 0; nblks = 0; acc = 0;
         q.delete();
         e_fold_vld = 0; e_smp_vld = 0; e_blk_vld = 0; e_done = 0;
      end else begin
         e_fold_vld = 0; e_smp_vld = 0; e_blk_vld = 0; e_done = 0;
         if (!run_en) begin
            m_fold = int'(fold_cfg); m_blk = int'(blk_cfg);
            cnt = 0; nbits = 0; nblks = 0; acc = 0;
            q.delete();
         end else begin
            raw = ^(osc_in & src_mask);
            acc = acc ^ raw;
            cnt++;
            if (cnt == ((m_fold == 0) ? 65536 : m_fold)) begin
               e_fold_vld = 1; e_fold_bit = acc;
               q.push_back(acc);
               acc = 0; cnt = 0; nbits++;
               if (nbits % 8 == 0) begin
                  e_smp_vld = 1;
                  for (int i = 0; i < 8; i++) e_byte = {e_byte[6:0], q[q.size()-8+i]};
               end
               if (nbits == BB) begin
                  e_blk_vld = 1;
                  for (int i = 0; i < BB; i++) e_blk = {e_blk[BB-2:0], q[i]};
                  q.delete();
                  nbits = 0; nblks++;
                  if (nblks == ((m_blk == 0) ? 256 : m_blk)) begin
                     e_done = 1; nblks = 0;
                  end
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [BB-1:0] act, input logic [BB-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         chk({fold_vld, smp_vld, blk_vld, done} === {e_fold_vld, e_smp_vld, e_blk_vld, e_done},
             "R3 R4 R5 R6 R7 strobes", BB'({fold_vld, smp_vld, blk_vld, done}),
             BB'({e_fold_vld, e_smp_vld, e_blk_vld, e_done}));
         if (e_fold_vld) chk(fold_bit === e_fold_bit, "R2 R3 fold bit", BB'(fold_bit), BB'(e_fold_bit));
         if (e_smp_vld)  chk(smp_byte === e_byte, "R4 sample byte", BB'(smp_byte), BB'(e_byte));
         if (e_blk_vld)  chk(blk_data === e_blk, "R5 block data", blk_data, e_blk);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [NS-1:0] m, input logic [7:0] f, input logic [7:0] b);
      run_en = 1'b0;
      src_mask = m; fold_cfg = f; blk_cfg = b;
      tick(2);
      run_en = 1'b1;
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int k;
      int seen;
      tick(3);
      chk({fold_vld, smp_vld, blk_vld, done} === 4'b0, "R1 reset strobes",
          BB'({fold_vld, smp_vld, blk_vld, done}), '0);
      rst_n = 1'b1;
      tick(1);
      chk({fold_vld, smp_vld, blk_vld, done} === 4'b0, "R1 after reset",
          BB'({fold_vld, smp_vld, blk_vld, done}), '0);

      // Full mask, unit fold, quota 2.
      restart('1, 8'd1, 8'd2);
      tick(600);
      // Sparse mask, fold 5, quota 1.
      restart(24'h00F0F1, 8'd5, 8'd1);
      tick(1500);

      // R2: all sources masked gives zero samples.
      restart('0, 8'd2, 8'd1);
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (smp_vld) begin seen++; chk(smp_byte === 8'h00, "R2 masked byte", BB'(smp_byte), '0); end
      end
      chk(seen > 0, "R2 masked bytes seen", BB'(seen), BB'(1));

      // R3: one toggling source folded in pairs gives ones.
      osc_toggle = 1'b1;
      restart(24'h000001, 8'd2, 8'd1);
      tick(40);
      @(negedge clk);
      while (!smp_vld) @(negedge clk);
      chk(smp_byte === 8'hFF, "R3 paired toggle byte", BB'(smp_byte), BB'(8'hFF));
      osc_toggle = 1'b0;

      // R7: stop mid-block, no strobes, fresh restart.
      restart('1, 8'd1, 8'd1);
      tick(37);
      run_en = 1'b0;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (fold_vld | smp_vld | blk_vld | done) seen++;
      end
      chk(seen == 0, "R7 strobes while stopped", BB'(seen), '0);
      run_en = 1'b1;
      tick(200);

      // R8: fold change while running is ignored.
      restart('1, 8'd4, 8'd1);
      tick(50);
      fold_cfg = 8'd1; blk_cfg = 8'd7;
      @(negedge clk);
      while (!fold_vld) @(negedge clk);
      k = 0;
      do begin @(negedge clk); k++; end while (!fold_vld);
      chk(k == 4, "R8 fold period kept", BB'(k), BB'(4));
      tick(300);

      // R6: quota 0 selects 256 blocks.
      restart('1, 8'd1, 8'd0);
      k = 0;
      do begin @(negedge clk); if (blk_vld) k++; end while (!done && k < 300);
      chk(k == 256 && done, "R6 quota zero", BB'(k), BB'(256));

      // R3: fold 0 selects 65536 raw bits.
      restart('1, 8'd0, 8'd1);
      k = 0;
      do begin @(negedge clk); k++; end while (!fold_vld && k < 70000);
      chk(k == 65536, "R3 fold zero", BB'(k), BB'(65536));
      run_en = 1'b0;
      tick(4);

      summary();
      $finish;
   end

endmodule